// File: doc/BRIEF.md
# Pipelined Burst Static RAM with Zero Bus Turnaround

This block models a small synchronous static RAM with an internal array organised as byte lanes of 9 bits each (four lanes, 36-bit words, by default). Every enabled rising clock edge is decoded into one cycle type: deselect, read, dummy read, write, write abort, stall or sleep. A load cycle takes the external address and opens a four-beat burst. An advance cycle moves to the next burst address and repeats the operation already in progress.

Reads and writes have the same two-edge latency. The address and control are sampled on one enabled edge, and the data moves on the second enabled edge after it. Because both directions use the same timing, reads and writes can alternate on every cycle without any idle gap on the bus.

The bus is modelled as an output word, a drive-enable flag and a separate write-data input. The output enable is combinational, and the drive flag drops whenever the device is writing, deselected, asleep or not output-enabled.

Top module: `nolat_burst_sram`

## Requirements
- R1: While reset is held and afterwards, until a read reaches its data phase, `dqDrive` is 0 whatever `outEnN` is. Advance cycles issued right after reset start no operation.
- R2: A load cycle (`advLoad`=0, `chipSelN`=0, `wrN`=1) starts a read at `addr`. On the second enabled edge after it, the addressed word goes on `dqOut` with `dqDrive`=1 for one cycle, provided `outEnN`=0 and `sleep`=0.
- R3: A load cycle with `wrN`=0 starts a write. `wrData` is sampled on the second enabled edge after the address cycle. Lane i (bits 9i+8..9i) is written only when `byteWrN[i]`=0, with the selects taken in the address cycle.
- R4: An advance cycle (`advLoad`=1) inside a burst repeats the burst's operation. The address takes the next value of its low two bits (modulo 4, linear, starting from the loaded address), and the upper bits keep the loaded value. `chipSelN`, `wrN` and `addr` are ignored in that cycle.
- R5: A load cycle with `chipSelN`=1 is a deselect and starts no operation. Advance cycles that follow it stay deselected, whatever `chipSelN` is.
- R6: A read whose data phase has `outEnN`=1 is a dummy read: `dqDrive` stays 0, but the burst address still advances.
- R7: A write beat with all four `byteWrN` bits high is an abort. It modifies no lane, but a continuing burst still advances past that address.
- R8: In the data phase of a write, `dqDrive` is 0 even with `outEnN`=0. Reads and writes can alternate on every cycle without idle cycles.
- R9: `outEnN` acts on `dqDrive` combinationally, within a clock period and without a clock edge.
- R10: An edge with `clkEnN`=1 (and `sleep`=0) changes no state. Such stalled edges do not count toward the two-edge latency, and `wrData` is not sampled on them.
- R11: `sleep`=1 forces `dqDrive` to 0 combinationally. An edge with `sleep`=1 acts as a deselect even when `clkEnN`=1: the pipeline moves on, and any burst ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEnN | input | 1 | Active-low clock enable; high stalls the edge |
| sleep | input | 1 | Sleep request; tri-states the bus and deselects |
| chipSelN | input | 1 | Active-low chip select, sampled on load cycles |
| advLoad | input | 1 | 1 advances the burst, 0 loads a new address |
| wrN | input | 1 | 0 write, 1 read, sampled on load cycles |
| byteWrN | input | LANES | Active-low byte lane write selects |
| addr | input | ADDR_W | Word address, used on load cycles |
| wrData | input | LANES*LANE_W | Write data, sampled in the write data phase |
| outEnN | input | 1 | Asynchronous active-low output enable |
| dqOut | output | LANES*LANE_W | Read data, zero when not driven |
| dqDrive | output | 1 | Bus drive enable (0 means tri-stated) |

## Verification
The bench keeps an arithmetic model of the array and of the two-edge pipeline. It sweeps all 16 byte-select patterns, bursts that start at every offset and wrap, and read/write sequences that alternate on every cycle. A design with the latency off by one edge, or one that counts stalled edges, would show data in the wrong cycle or sample `wrData` at the wrong time. A design that resets the wrap or lets the upper address bits carry would return neighbouring words. A design that writes on an all-high abort, or that lets `outEnN` through during a write, would corrupt data or drive during a write. The bench also toggles `outEnN` and `sleep` in mid-cycle to catch a registered output enable. It checks that a deselect, or a sleep edge, ends a burst so that later advance cycles do nothing.

// File: rtl/nolat_burst_sram_pkg.sv
package nolat_burst_sram_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // strobes from the control to the datapath for the data-phase beat
  typedef struct packed {
    logic step;
    logic wrEn;
    logic rdEn;
  } strobe_t;

endpackage

// File: rtl/nolat_burst_sram_ctrl.sv
module nolat_burst_sram_ctrl
  import nolat_burst_sram_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int LANES     = 4,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              sleep,
  input  logic              chipSelN,
  input  logic              advLoad,
  input  logic              wrN,
  input  logic [LANES-1:0]  byteWrN,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strobe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  memMask
);

  localparam int BCW = $clog2(BURST_LEN);

  typedef struct packed {
    op_e               op;
    logic [ADDR_W-1:0] a;
    logic [LANES-1:0]  m;
  } slot_t;

  slot_t             s1, s2, nxt;
  op_e               burstOp;
  logic [ADDR_W-1:0] baseAddr;
  logic [BCW-1:0]    beat, beatNext;
  logic              step;

  assign step     = !clkEnN || sleep;
  assign beatNext = beat + 1'b1;

  // decode of the current edge into the beat that enters the pipeline
  always_comb begin
    nxt.op = OP_NONE;
    nxt.a  = '0;
    nxt.m  = '0;
    if (!sleep) begin
      if (!advLoad) begin
        if (!chipSelN) begin
          nxt.op = wrN ? OP_READ : OP_WRITE;
          nxt.a  = addr;
          nxt.m  = wrN ? '0 : ~byteWrN;
        end
      end else if (burstOp != OP_NONE) begin
        nxt.op = burstOp;
        nxt.a  = {baseAddr[ADDR_W-1:BCW], beatNext};
        nxt.m  = (burstOp == OP_WRITE) ? ~byteWrN : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstOp  <= OP_NONE;
      baseAddr <= '0;
      beat     <= '0;
      s1       <= '{op: OP_NONE, a: '0, m: '0};
      s2       <= '{op: OP_NONE, a: '0, m: '0};
    end else if (step) begin
      s2 <= s1;
      s1 <= nxt;
      if (sleep || (!advLoad && chipSelN)) begin
        burstOp <= OP_NONE;
      end else if (!advLoad) begin
        burstOp  <= nxt.op;
        baseAddr <= addr;
        beat     <= addr[BCW-1:0];
      end else if (burstOp != OP_NONE) begin
        beat <= beatNext;
      end
    end
  end

  assign strobe.step = step;
  assign strobe.wrEn = (s2.op == OP_WRITE) && (|s2.m);
  assign strobe.rdEn = (s2.op == OP_READ);
  assign memAddr     = s2.a;
  assign memMask     = s2.m;

  // R10: a stalled edge leaves the whole pipeline and burst state alone
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !step |=> $stable(s1) && $stable(s2) && $stable(beat) && $stable(burstOp));

  // R5: a deselect injects no operation and closes the burst
  p_desel_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    step && !sleep && !advLoad && chipSelN |=> s1.op == OP_NONE && burstOp == OP_NONE);

  // R4: a continuation keeps the operation and the upper address bits
  p_burst_upper_r4: assert property (@(posedge clk) disable iff (!rstN)
    step && !sleep && advLoad && burstOp != OP_NONE
      |=> s1.op == $past(burstOp) && s1.a[ADDR_W-1:BCW] == $past(baseAddr[ADDR_W-1:BCW]));

  // R11: a sleep edge ends any burst and injects nothing
  p_sleep_ends_r11: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> burstOp == OP_NONE && s1.op == OP_NONE);

endmodule

// File: rtl/nolat_burst_sram_dp.sv
module nolat_burst_sram_dp
  import nolat_burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strobe,
  input  logic [ADDR_W-1:0]       memAddr,
  input  logic [LANES-1:0]        memMask,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic                    outEnN,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dqOut,
  output logic                    dqDrive
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int DW    = LANES * LANE_W;

  logic [DW-1:0] rdWord;
  logic          rdValid;

  // one storage array and one read register per byte lane
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] store [DEPTH];
    logic [LANE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (strobe.step && strobe.wrEn && memMask[g])
        store[memAddr] <= wrData[g*LANE_W +: LANE_W];
      if (strobe.step && strobe.rdEn)
        q <= store[memAddr];
    end
    assign rdWord[g*LANE_W +: LANE_W] = q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdValid <= 1'b0;
    else if (strobe.step) rdValid <= strobe.rdEn;
  end

  assign dqDrive = rdValid && !outEnN && !sleep;
  assign dqOut   = dqDrive ? rdWord : '0;

  // R8: after any enabled edge that carried no read, the bus is released
  p_quiet_after_nonread_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step && !strobe.rdEn |=> !dqDrive);

  // R10: stalled edges hold the read register and its valid flag
  p_stall_data_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.step |=> $stable(rdWord) && $stable(rdValid));

endmodule

// File: rtl/nolat_burst_sram.sv
module nolat_burst_sram
  import nolat_burst_sram_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int LANES     = 4,
  parameter int LANE_W    = 9,
  parameter int BURST_LEN = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clkEnN,
  input  logic                    sleep,
  input  logic                    chipSelN,
  input  logic                    advLoad,
  input  logic                    wrN,
  input  logic [LANES-1:0]        byteWrN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic                    outEnN,
  output logic [LANES*LANE_W-1:0] dqOut,
  output logic                    dqDrive
);

  strobe_t           strobe;
  logic [ADDR_W-1:0] memAddr;
  logic [LANES-1:0]  memMask;

  nolat_burst_sram_ctrl #(
    .ADDR_W(ADDR_W), .LANES(LANES), .BURST_LEN(BURST_LEN)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .sleep(sleep),
    .chipSelN(chipSelN), .advLoad(advLoad), .wrN(wrN), .byteWrN(byteWrN),
    .addr(addr), .strobe(strobe), .memAddr(memAddr), .memMask(memMask)
  );

  nolat_burst_sram_dp #(
    .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memAddr(memAddr),
    .memMask(memMask), .wrData(wrData), .outEnN(outEnN), .sleep(sleep),
    .dqOut(dqOut), .dqDrive(dqDrive)
  );

endmodule

// File: tb/nolat_burst_sram_test.sv
module nolat_burst_sram_test;
  localparam int  AW = 5;
  localparam int  LANES = 4;
  localparam int  LW = 9;
  localparam int  DW = LANES * LW;
  localparam int  DEPTH = 1 << AW;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rstN, clkEnN, sleep, chipSelN, advLoad, wrN, outEnN;
  logic [LANES-1:0] byteWrN;
  logic [AW-1:0]    addr;
  logic [DW-1:0]    wrData, dqOut;
  logic             dqDrive;

  nolat_burst_sram #(.ADDR_W(AW), .LANES(LANES), .LANE_W(LW), .BURST_LEN(4)) uut (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .sleep(sleep), .chipSelN(chipSelN),
    .advLoad(advLoad), .wrN(wrN), .byteWrN(byteWrN), .addr(addr), .wrData(wrData),
    .outEnN(outEnN), .dqOut(dqOut), .dqDrive(dqDrive)
  );

  int total = 0;
  int bad = 0;
  string curTag = "R1";

  // reference model: array, burst state, two-slot pipeline (0 none, 1 read, 2 write)
  logic [DW-1:0]    refMem [DEPTH];
  int               mBurst;
  logic [AW-1:0]    mBase;
  logic [1:0]       mBeat;
  int               pOp [2];
  logic [AW-1:0]    pAddr [2];
  logic [LANES-1:0] pMask [2];
  logic             expValid;
  logic [DW-1:0]    expData;
  int               salt;

  function automatic logic [DW-1:0] dataFor(input logic [AW-1:0] a, input int s);
    logic [DW-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*LW +: LW] = LW'(int'(a) * 13 + s * 5 + i * 3 + 1);
    return v;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [DW-1:0] got, input logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  task automatic checkBus();
    logic expDrive;
    expDrive = expValid && !outEnN && !sleep;
    check(curTag, "drive", DW'(dqDrive), DW'(expDrive));
    check(curTag, "data", dqOut, expDrive ? expData : '0);
  endtask

  // one clock cycle: drive at negedge, update the model at the edge, check at next negedge
  task automatic cyc(input logic ce, input logic cs, input logic adv, input logic we,
                     input logic [3:0] bw, input logic [AW-1:0] a,
                     input logic oe, input logic slp);
    int nOp;
    logic [AW-1:0] nA;
    logic [LANES-1:0] nM;
    clkEnN = ce; chipSelN = cs; advLoad = adv; wrN = we; byteWrN = bw;
    addr = a; outEnN = oe; sleep = slp;
    wrData = (ce && !slp) ? {DW{1'b1}} : dataFor(pAddr[1], salt);
    @(posedge clk);
    if (!ce || slp) begin
      if (pOp[1] == 2)
        for (int i = 0; i < LANES; i++)
          if (pMask[1][i]) refMem[pAddr[1]][i*LW +: LW] = wrData[i*LW +: LW];
      expValid = (pOp[1] == 1);
      if (expValid) expData = refMem[pAddr[1]];
      nOp = 0; nA = '0; nM = '0;
      if (slp) mBurst = 0;
      else if (!adv) begin
        if (cs) mBurst = 0;
        else begin
          nOp = we ? 1 : 2; nA = a; nM = we ? '0 : ~bw;
          mBurst = nOp; mBase = a; mBeat = a[1:0];
        end
      end else if (mBurst != 0) begin
        mBeat = mBeat + 2'd1;
        nOp = mBurst; nA = {mBase[AW-1:2], mBeat}; nM = (mBurst == 2) ? ~bw : '0;
      end
      pOp[1] = pOp[0]; pAddr[1] = pAddr[0]; pMask[1] = pMask[0];
      pOp[0] = nOp;    pAddr[0] = nA;       pMask[0] = nM;
    end
    @(negedge clk);
    checkBus();
  endtask

  task automatic loadRd(input logic [AW-1:0] a, input logic oe = 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 4'hF, a, oe, 1'b0);
  endtask
  task automatic loadWr(input logic [AW-1:0] a, input logic [3:0] bw);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, bw, a, 1'b0, 1'b0);
  endtask
  // continuation with chip select off, write enable low and a junk address: all ignored (R4)
  task automatic cont(input logic [3:0] bw = 4'h0, input logic oe = 1'b0);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, bw, '1, oe, 1'b0);
  endtask
  task automatic stall();
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 5'd13, 1'b0, 1'b0);
  endtask
  task automatic desel(input logic oe = 1'b0);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 4'hF, '0, oe, 1'b0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog got=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; clkEnN = 1'b0; sleep = 1'b0; chipSelN = 1'b1; advLoad = 1'b1;
    wrN = 1'b1; byteWrN = '1; addr = '0; wrData = '0; outEnN = 1'b0;
    mBurst = 0; mBase = '0; mBeat = '0; expValid = 1'b0; expData = '0; salt = 0;
    for (int k = 0; k < 2; k++) begin pOp[k] = 0; pAddr[k] = '0; pMask[k] = '0; end
    for (int k = 0; k < DEPTH; k++) refMem[k] = '0;

    // R1: reset state, output enable already active
    repeat (3) @(negedge clk);
    check("R1", "drive in reset", DW'(dqDrive), '0);
    rstN = 1'b1;
    curTag = "R1";
    repeat (4) cyc(1'b0, 1'b0, 1'b1, 1'b1, 4'hF, '0, 1'b0, 1'b0);

    // R3 R4: fill the array with four-beat write bursts
    curTag = "R3";
    for (int b = 0; b < DEPTH; b += 4) begin
      loadWr(AW'(b), 4'h0);
      repeat (3) cont(4'h0);
    end
    desel(); desel();

    // R2 R4: read back with bursts starting at every offset (wrap exercised)
    curTag = "R4";
    for (int b = 0; b < DEPTH; b += 4) begin
      loadRd(AW'(b + (b / 4) % 4));
      repeat (3) cont(4'h0);
    end
    desel(); desel();

    // R3 R7: every byte select pattern, back-to-back single-beat writes
    curTag = "R7";
    salt = 3;
    for (int m = 0; m < 16; m++) loadWr(AW'(m), 4'(m));
    // continuing burst with abort beats in between
    loadWr(5'd16, 4'h0); cont(4'hF); cont(4'h0); cont(4'hF);
    desel(); desel();
    curTag = "R3";
    for (int b = 0; b < 20; b += 4) begin
      loadRd(AW'(b));
      repeat (3) cont(4'h0);
    end
    desel(); desel();

    // R6: dummy reads still advance the address
    curTag = "R6";
    loadRd(5'd20, 1'b1); cont(4'hF, 1'b1); cont(4'hF, 1'b1); cont(4'hF, 1'b1);
    desel(1'b0); desel(1'b0);

    // R10: stalls inside read and write bursts, junk inputs while stalled
    curTag = "R10";
    loadRd(5'd5); stall(); cont(); stall(); stall(); cont(); cont(); stall();
    desel(); desel();
    salt = 7;
    loadWr(5'd24, 4'h0); stall(); cont(4'h0); stall(); cont(4'b1010); stall(); stall();
    cont(4'h0); desel(); stall(); desel(); desel();
    loadRd(5'd24); repeat (3) cont(); desel(); desel();

    // R5: deselect, then advance cycles with chip select active stay idle
    curTag = "R5";
    loadRd(5'd8); desel();
    repeat (3) cyc(1'b0, 1'b0, 1'b1, 1'b1, 4'hF, '0, 1'b0, 1'b0);
    desel(); desel();

    // R8: read and write alternating every cycle, output enable held active
    curTag = "R8";
    salt = 9;
    loadWr(5'd28, 4'h0); loadRd(5'd1); loadWr(5'd29, 4'b0011); loadRd(5'd28);
    loadRd(5'd29); loadWr(5'd30, 4'h0); loadRd(5'd30); desel(); desel(); desel();

    // R9: output enable acts without a clock edge
    curTag = "R9";
    loadRd(5'd2); desel(); desel();
    outEnN = 1'b1; #1;
    check("R9", "drive with outEnN high", DW'(dqDrive), '0);
    outEnN = 1'b0; #1;
    check("R9", "drive with outEnN low", DW'(dqDrive), DW'(1'b1));
    check("R9", "data with outEnN low", dqOut, refMem[2]);
    // R8: toggling output enable during a write data phase never drives
    loadWr(5'd3, 4'h0); desel(); desel();
    outEnN = 1'b1; #1; outEnN = 1'b0; #1;
    check("R8", "drive in write phase", DW'(dqDrive), '0);
    desel(); desel();

    // R11: sleep releases the bus at once and ends the burst
    curTag = "R11";
    loadRd(5'd10); cont(); cont();
    sleep = 1'b1; #1;
    check("R11", "drive while asleep", DW'(dqDrive), '0);
    sleep = 1'b0; #1;
    check("R11", "drive after wake", DW'(dqDrive), DW'(1'b1));
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 4'hF, '0, 1'b0, 1'b1);
    repeat (3) cont();
    loadRd(5'd12);
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 4'hF, '0, 1'b0, 1'b1);
    repeat (3) cont();
    desel(); desel();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule